// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The block gathers interrupt requests for a processor and presents them on two outputs. Source 0 is a fast line that drives the fast output on its own. Sources 1 to 6 are external request lines, and the sources after them are on-chip peripheral lines. All of these drive the normal output. Each source has a configuration register and a vector register, both set through a simple single-cycle register port. The configuration register holds an enable, a trigger type and a priority from 0 to 7. The vector register holds the handler address.

The processor acknowledges a normal interrupt by reading the vector register. The block returns the vector of the winning source, clears that source's latched edge and pushes the winner's priority onto an eight-entry level stack. While a level is on the stack, only sources with a strictly higher priority can raise the normal output, so handlers nest. An end-of-interrupt write pops one level. If nothing is eligible at the moment of the read, a programmable spurious vector is returned and no state changes.

In protect mode a read of the vector register returns the same value but changes nothing, so a debugger can inspect it freely. The state change then happens on a write to the vector register.

Top module: `vpic_top`

## Requirements
- R1: After reset every source is disabled and reads back its configuration as 0x10 (disabled, high level, priority 0), and both `irq_o` and `fiq_o` are low. A disabled source never raises either output, whatever its line does.
- R2: Configuration byte layout: bits [2:0] are the priority, bits [5:4] are the trigger and bit 7 is the enable. A read of the interrupt vector at address 0x80 returns the vector of the eligible normal source with the highest priority. Among equal priorities the lowest source number wins.
- R3: Source 0 (`fiq_line_i`) drives only `fiq_o` and never `irq_o`. A read at address 0x84 returns the vector of source 0 while `fiq_o` is high.
- R4: After a vector read has acquired priority P, `irq_o` is raised only by a source whose priority is strictly above P. A source at P or below stays silent.
- R5: The level stack holds up to 8 nested levels. A write to address 0x81 pops one level and restores the previous level.
- R6: If no eligible source exists when the vector is read, the spurious vector (written at 0x82) is returned and the current level is unchanged.
- R7: Trigger codes: 0 = active-low level, 1 = active-high level, 2 = falling edge, 3 = rising edge. Level sources follow their line. Edge sources latch a pending bit that stays set after the line returns, and the vector read that selects the source clears it.
- R8: With protect mode on (bit 0 of address 0x83), a vector read returns the winner but leaves the level and the pending bits unchanged. A write to 0x80 then performs the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fiq_line_i | input | 1 | Fast interrupt line (source 0) |
| ext_irq_i | input | NUM_EXT | External request lines (sources 1..NUM_EXT) |
| per_irq_i | input | NUM_PER | Peripheral request lines (following sources) |
| bus_sel_i | input | 1 | Register access select |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 8 | Register address: [7:6] region (0 config, 1 vector, 2 control), [5:0] index |
| bus_wdata_i | input | VEC_W | Write data |
| bus_rdata_o | output | VEC_W | Read data, valid in the cycle of the read |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest state to reach is a full stack of eight nested levels followed by a waiting request that must not interrupt. The bench fires rising-edge sources one at a time with priorities climbing from 0 to 7 and acknowledges each before firing the next. It then pulses a further source at priority 7 and expects silence until one end-of-interrupt uncovers it. Protect mode is harder still to confirm from the ports. The bench relies on a lower-priority level source that stays silent only if the write to 0x80, and not the earlier read, pushed the level.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

    localparam int NUM_LVL = 8;
    localparam int LVL_W   = $clog2(NUM_LVL);

    typedef struct packed {
        logic             en;
        logic [1:0]       trig;
        logic [LVL_W-1:0] prio;
    } cfg_t;

    localparam logic [1:0] TRIG_LOW  = 2'd0;
    localparam logic [1:0] TRIG_HIGH = 2'd1;
    localparam logic [1:0] TRIG_FALL = 2'd2;
    localparam logic [1:0] TRIG_RISE = 2'd3;

    localparam logic [1:0] RG_CFG = 2'd0;
    localparam logic [1:0] RG_VEC = 2'd1;
    localparam logic [1:0] RG_CTL = 2'd2;

    localparam logic [5:0] OFS_IVR  = 6'd0;
    localparam logic [5:0] OFS_EOI  = 6'd1;
    localparam logic [5:0] OFS_SPU  = 6'd2;
    localparam logic [5:0] OFS_PROT = 6'd3;
    localparam logic [5:0] OFS_FVR  = 6'd4;

    localparam cfg_t CFG_RST = '{en: 1'b0, trig: TRIG_HIGH, prio: '0};

    function automatic logic [7:0] pack_cfg(cfg_t c);
        return {c.en, 1'b0, c.trig, 1'b0, c.prio};
    endfunction

endpackage

// File: rtl/vpic_src.sv
module vpic_src (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    input  logic [1:0] trig_i,
    input  logic       clr_i,
    output logic       active_o
);
    typedef struct packed {
        logic prev;
        logic pend;
    } src_st_t;

    src_st_t st_q, st_d;
    logic    edge_mode, hit, fire;

    always_comb begin
        edge_mode = trig_i[1];
        hit       = (line_i == trig_i[0]);
        fire      = hit & ~st_q.prev;
        st_d      = st_q;
        st_d.prev = hit;
        st_d.pend = edge_mode & (fire | (st_q.pend & ~clr_i));
        active_o  = edge_mode ? st_q.pend : hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= 1'b1;
            st_q.pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && hit && !st_q.prev) |=> st_q.pend) else $error("edge not latched"); // R7
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(hit && !st_q.prev)) |=> !st_q.pend) else $error("pending kept"); // R7

endmodule

// File: rtl/vpic_arb.sv
module vpic_arb #(
    parameter int N  = 15,
    parameter int IW = 4,
    parameter int LW = 3
) (
    input  logic [N-1:0]         act_i,
    input  logic [N-1:0]         en_i,
    input  logic [N-1:0][LW-1:0] prio_i,
    input  logic [LW-1:0]        lvl_i,
    input  logic                 lvl_any_i,
    output logic                 win_o,
    output logic [IW-1:0]        idx_o,
    output logic [LW-1:0]        prio_o,
    output logic [N-1:0]         gnt_o
);
    logic [N-1:0] elig;

    for (genvar g = 0; g < N; g++) begin : g_elig
        assign elig[g] = act_i[g] & en_i[g] & (~lvl_any_i | (prio_i[g] > lvl_i));
    end

    always_comb begin
        win_o  = 1'b0;
        idx_o  = '0;
        prio_o = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!win_o || prio_i[i] > prio_o)) begin
                win_o  = 1'b1;
                idx_o  = IW'(i);
                prio_o = prio_i[i];
            end
        end
        gnt_o = '0;
        for (int i = 0; i < N; i++) begin
            gnt_o[i] = win_o && (idx_o == IW'(i));
        end
    end

endmodule

// File: rtl/vpic_stack.sv
module vpic_stack #(
    parameter int DEPTH = 8,
    parameter int LW    = 3,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [LW-1:0] lvl_i,
    output logic [LW-1:0] top_o,
    output logic          empty_o,
    output logic [CW-1:0] cnt_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][LW-1:0] mem;
        logic [CW-1:0]            cnt;
    } stk_st_t;

    stk_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (push_i && (st_q.cnt < CW'(DEPTH))) begin
            st_d.mem[PW'(st_q.cnt)] = lvl_i;
            st_d.cnt                = st_q.cnt + 1'b1;
        end else if (pop_i && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        empty_o = (st_q.cnt == '0);
        top_o   = empty_o ? '0 : st_q.mem[PW'(st_q.cnt - 1'b1)];
        cnt_o   = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mem <= '0;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (st_q.cnt < CW'(DEPTH))) else $error("stack overflow"); // R5
    AST_EOI_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !empty_o) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1)) else $error("pop lost"); // R5

endmodule

// File: rtl/vpic_top.sv
module vpic_top
    import vpic_pkg::*;
#(
    parameter int NUM_EXT = 6,
    parameter int NUM_PER = 9,
    parameter int VEC_W   = 32,
    parameter int DEPTH   = NUM_LVL
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fiq_line_i,
    input  logic [NUM_EXT-1:0] ext_irq_i,
    input  logic [NUM_PER-1:0] per_irq_i,
    input  logic               bus_sel_i,
    input  logic               bus_rd_i,
    input  logic               bus_wr_i,
    input  logic [7:0]         bus_addr_i,
    input  logic [VEC_W-1:0]   bus_wdata_i,
    output logic [VEC_W-1:0]   bus_rdata_o,
    output logic               irq_o,
    output logic               fiq_o
);
    localparam int NSRC   = 1 + NUM_EXT + NUM_PER;
    localparam int NORM   = NSRC - 1;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int NIDX_W = (NORM > 1) ? $clog2(NORM) : 1;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    typedef struct packed {
        cfg_t [NSRC-1:0]            cfg;
        logic [NSRC-1:0][VEC_W-1:0] vec;
        logic [VEC_W-1:0]           spur;
        logic                       prot;
    } top_st_t;

    top_st_t st_q, st_d;

    logic [NSRC-1:0]            lines, act, clr;
    logic [NORM-1:0]            n_en, gnt;
    logic [NORM-1:0][LVL_W-1:0] n_prio;
    logic                       win;
    logic [NIDX_W-1:0]          win_n;
    logic [IDX_W-1:0]           win_src;
    logic [LVL_W-1:0]           win_prio, stk_top;
    logic                       stk_empty, push, pop;
    logic [CNT_W-1:0]           stk_cnt;

    logic                       rd, wr, in_range;
    logic [1:0]                 region;
    logic [5:0]                 ofs;
    logic [IDX_W-1:0]           sidx;
    logic                       is_ivr, is_fvr, ivr_act, fvr_act;

    assign lines = {per_irq_i, ext_irq_i, fiq_line_i};

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        vpic_src u_src (
            .clk      (clk),
            .rst_n    (rst_n),
            .line_i   (lines[g]),
            .trig_i   (st_q.cfg[g].trig),
            .clr_i    (clr[g]),
            .active_o (act[g])
        );
    end

    for (genvar g = 1; g < NSRC; g++) begin : g_norm
        assign n_en[g-1]   = st_q.cfg[g].en;
        assign n_prio[g-1] = st_q.cfg[g].prio;
    end

    vpic_arb #(.N(NORM), .IW(NIDX_W), .LW(LVL_W)) u_arb (
        .act_i     (act[NSRC-1:1]),
        .en_i      (n_en),
        .prio_i    (n_prio),
        .lvl_i     (stk_top),
        .lvl_any_i (~stk_empty),
        .win_o     (win),
        .idx_o     (win_n),
        .prio_o    (win_prio),
        .gnt_o     (gnt)
    );

    vpic_stack #(.DEPTH(DEPTH), .LW(LVL_W), .CW(CNT_W)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push),
        .pop_i   (pop),
        .lvl_i   (win_prio),
        .top_o   (stk_top),
        .empty_o (stk_empty),
        .cnt_o   (stk_cnt)
    );

    // Decode and acknowledge control
    always_comb begin
        rd       = bus_sel_i & bus_rd_i;
        wr       = bus_sel_i & bus_wr_i;
        region   = bus_addr_i[7:6];
        ofs      = bus_addr_i[5:0];
        sidx     = ofs[IDX_W-1:0];
        in_range = (32'(ofs) < NSRC);
        is_ivr   = (region == RG_CTL) && (ofs == OFS_IVR);
        is_fvr   = (region == RG_CTL) && (ofs == OFS_FVR);
        ivr_act  = is_ivr & (st_q.prot ? wr : rd);
        fvr_act  = is_fvr & (st_q.prot ? wr : rd);
        push     = ivr_act & win;
        pop      = wr && (region == RG_CTL) && (ofs == OFS_EOI);
        win_src  = IDX_W'(win_n) + IDX_W'(1);
        clr      = {(push ? gnt : '0), fvr_act};
        irq_o    = win;
        fiq_o    = act[0] & st_q.cfg[0].en;
    end

    // Register file next state
    always_comb begin
        st_d = st_q;
        if (wr) begin
            case (region)
                RG_CFG: if (in_range) begin
                    st_d.cfg[sidx].en   = bus_wdata_i[7];
                    st_d.cfg[sidx].trig = bus_wdata_i[5:4];
                    st_d.cfg[sidx].prio = bus_wdata_i[2:0];
                end
                RG_VEC: if (in_range) st_d.vec[sidx] = bus_wdata_i;
                RG_CTL: begin
                    if (ofs == OFS_SPU)  st_d.spur = bus_wdata_i;
                    if (ofs == OFS_PROT) st_d.prot = bus_wdata_i[0];
                end
                default: ;
            endcase
        end
    end

    // Read data
    always_comb begin
        bus_rdata_o = '0;
        case (region)
            RG_CFG: if (in_range) bus_rdata_o = VEC_W'(pack_cfg(st_q.cfg[sidx]));
            RG_VEC: if (in_range) bus_rdata_o = st_q.vec[sidx];
            RG_CTL: begin
                if (ofs == OFS_IVR)  bus_rdata_o = win ? st_q.vec[win_src] : st_q.spur;
                if (ofs == OFS_FVR)  bus_rdata_o = fiq_o ? st_q.vec[0] : st_q.spur;
                if (ofs == OFS_SPU)  bus_rdata_o = st_q.spur;
                if (ofs == OFS_PROT) bus_rdata_o = VEC_W'(st_q.prot);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSRC; i++) st_q.cfg[i] <= CFG_RST;
            st_q.vec  <= '0;
            st_q.spur <= '0;
            st_q.prot <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_IRQ_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !stk_empty) |-> (win_prio > stk_top)) else $error("nesting broken"); // R4
    AST_PUSH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (stk_top == $past(win_prio))) else $error("level not acquired"); // R2
    AST_SPUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ivr_act && !win) |=> $stable(stk_cnt)) else $error("spurious changed level"); // R6
    AST_PROT_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.prot && rd && is_ivr && !pop) |=> $stable(stk_cnt)) else $error("protected read moved state"); // R8

endmodule

// File: tb/vpic_top_test.sv
module vpic_top_test;
    localparam int NUM_EXT = 6;
    localparam int NUM_PER = 9;
    localparam int NSRC    = 1 + NUM_EXT + NUM_PER;
    localparam logic [31:0] SPUR = 32'hDEAD_0000;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               fiq_line = 1'b0;
    logic [NUM_EXT-1:0] ext_irq = '0;
    logic [NUM_PER-1:0] per_irq = '0;
    logic               sel = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [7:0]         addr = '0;
    logic [31:0]        wdata = '0;
    logic [31:0]        rdata;
    logic               irq, fiq;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    vpic_top #(.NUM_EXT(NUM_EXT), .NUM_PER(NUM_PER), .VEC_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .fiq_line_i(fiq_line), .ext_irq_i(ext_irq),
        .per_irq_i(per_irq), .bus_sel_i(sel), .bus_rd_i(rd), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_o(irq), .fiq_o(fiq)
    );

    function automatic logic [31:0] vec_of(int s);
        return 32'h1000 + 32'(s) * 32'h10;
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic reg_wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic reg_rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0; rd = 1'b0;
    endtask

    task automatic set_line(int s, logic v);
        @(negedge clk);
        if (s == 0) fiq_line = v;
        else if (s <= NUM_EXT) ext_irq[s-1] = v;
        else per_irq[s-1-NUM_EXT] = v;
        #1;
    endtask

    task automatic pulse(int s);
        set_line(s, 1'b1);
        set_line(s, 1'b0);
    endtask

    task automatic cfg(int s, logic en, logic [1:0] trig, int prio);
        reg_wr({2'b00, 6'(s)}, {24'h0, en, 1'b0, trig, 1'b0, 3'(prio)});
    endtask

    task automatic do_reset();
        rst_n = 1'b0; fiq_line = 1'b0; ext_irq = '0; per_irq = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < NSRC; s++) reg_wr({2'b01, 6'(s)}, vec_of(s));
        reg_wr(8'h82, SPUR);
        #1;
    endtask

    task automatic test_reset();
        logic [31:0] d;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check("R1 irq in reset", 32'(irq), 0);
        check("R1 fiq in reset", 32'(fiq), 0);
        do_reset();
        reg_rd(8'h03, d);
        check("R1 reset config", d, 32'h10);
        reg_rd(8'h80, d);
        check("R6 idle vector read", d, SPUR);
    endtask

    task automatic test_mask();
        set_line(3, 1'b1);
        cfg(3, 1'b0, 2'd1, 2);
        #1 check("R1 masked source silent", 32'(irq), 0);
        cfg(3, 1'b1, 2'd1, 2);
        #1 check("R1 enabled source raises irq", 32'(irq), 1);
        set_line(0, 1'b1);
        check("R1 masked fast line silent", 32'(fiq), 0);
    endtask

    task automatic test_priority();
        logic [31:0] d;
        do_reset();
        set_line(2, 1'b1); set_line(4, 1'b1); set_line(5, 1'b1);
        cfg(2, 1'b1, 2'd1, 3);
        cfg(5, 1'b1, 2'd1, 5);
        cfg(4, 1'b1, 2'd1, 5);
        reg_rd(8'h80, d);
        check("R2 tie goes to lowest number", d, vec_of(4));
        #1 check("R4 equal priority blocked", 32'(irq), 0);
        reg_wr(8'h81, 0);
        #1 check("R5 eoi restores level", 32'(irq), 1);
        reg_rd(8'h80, d);
        check("R2 winner after eoi", d, vec_of(4));
        reg_wr(8'h81, 0);
    endtask

    task automatic test_fast();
        logic [31:0] d;
        do_reset();
        cfg(0, 1'b1, 2'd1, 0);
        set_line(0, 1'b1);
        check("R3 fast output", 32'(fiq), 1);
        check("R3 normal output untouched", 32'(irq), 0);
        reg_rd(8'h84, d);
        check("R3 fast vector", d, vec_of(0));
    endtask

    task automatic test_nesting();
        logic [31:0] d;
        do_reset();
        for (int k = 1; k <= 9; k++) cfg(k, 1'b1, 2'd3, (k == 9) ? 7 : k - 1);
        for (int k = 1; k <= 8; k++) begin
            pulse(k);
            check("R4 higher level interrupts", 32'(irq), 1);
            reg_rd(8'h80, d);
            check("R5 nested vector", d, vec_of(k));
        end
        pulse(9);
        check("R4 full stack blocks level 7", 32'(irq), 0);
        reg_wr(8'h81, 0);
        #1 check("R5 pop uncovers waiting source", 32'(irq), 1);
        reg_rd(8'h80, d);
        check("R5 vector after pop", d, vec_of(9));
    endtask

    task automatic test_spurious();
        logic [31:0] d;
        do_reset();
        set_line(3, 1'b1);
        cfg(3, 1'b1, 2'd1, 1);
        set_line(3, 1'b0);
        reg_rd(8'h80, d);
        check("R6 vanished request gives spurious", d, SPUR);
        set_line(3, 1'b1);
        check("R6 level not raised by spurious", 32'(irq), 1);
        reg_rd(8'h80, d);
        check("R6 real vector afterwards", d, vec_of(3));
    endtask

    task automatic test_trigger();
        logic [31:0] d;
        do_reset();
        cfg(6, 1'b1, 2'd0, 1);
        #1 check("R7 low level active", 32'(irq), 1);
        set_line(6, 1'b1);
        check("R7 low level released", 32'(irq), 0);
        cfg(6, 1'b0, 2'd0, 1);
        set_line(7, 1'b1);
        cfg(7, 1'b1, 2'd2, 2);
        #1 check("R7 falling idle", 32'(irq), 0);
        set_line(7, 1'b0);
        @(negedge clk); #1;
        check("R7 falling edge latched", 32'(irq), 1);
        set_line(7, 1'b1);
        check("R7 latch holds", 32'(irq), 1);
        reg_rd(8'h80, d);
        check("R7 edge vector", d, vec_of(7));
        reg_wr(8'h81, 0);
        #1 check("R7 read cleared pending", 32'(irq), 0);
    endtask

    task automatic test_protect();
        logic [31:0] d;
        do_reset();
        reg_wr(8'h83, 1);
        set_line(3, 1'b1);
        cfg(3, 1'b1, 2'd1, 2);
        cfg(2, 1'b1, 2'd3, 4);
        pulse(2);
        reg_rd(8'h80, d);
        check("R8 protected read value", d, vec_of(2));
        reg_rd(8'h80, d);
        check("R8 read left state", d, vec_of(2));
        reg_wr(8'h80, 0);
        #1 check("R8 write acknowledges", 32'(irq), 0);
        reg_wr(8'h81, 0);
        #1 check("R8 pending cleared by write", 32'(irq), 1);
        reg_rd(8'h80, d);
        check("R8 remaining source", d, vec_of(3));
    endtask

    initial begin
        #(4 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        test_mask();
        test_priority();
        test_fast();
        test_nesting();
        test_spurious();
        test_trigger();
        test_protect();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule